// File: doc/BRIEF.md
# Three-State Controller with Arrival and Departure Action Strobes

This block is a small clocked controller with three states. It waits in an idle state and holds a level output high. When an advance request arrives it walks through two single-cycle states and then returns to idle. Beside the state code it produces action signals in the style of a behavioural state chart. An arrival strobe pulses once each time a state is entered. A departure strobe pulses once each time a state is left. A level output stays high for as long as the idle state is held.

Two ways of producing the strobes are offered, and a parameter selects one. The first keeps a registered copy of the previous state and compares it with the current state. The second registers the strobes directly on the transition that the next-state logic takes. Both give the same behaviour at the ports, so a user picks between them for area or timing reasons only.

Top module: `entry_exit_fsm`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is 0, each clock edge puts the state at the idle code 0, and every bit of `arrive_o` and `depart_o` reads 0.
- R2: State codes are 0 (idle), 1 (first step) and 2 (second step). In idle, a clock edge with `adv_i`=1 moves to code 1. A clock edge with `adv_i`=0 keeps code 0.
- R3: Code 1 lasts exactly one cycle and then goes to code 2. Code 2 lasts exactly one cycle and then goes to code 0. `adv_i` has no effect in either of them.
- R4: `busy_n_o` (the level action) is 1 whenever the state is 0, and 0 in states 1 and 2.
- R5: `arrive_o[k]` is 1 for exactly the first cycle in which state k is visible on `state_o` after a change. It is 0 on every cycle where the state equals the state of the cycle before, and at most one bit is set.
- R6: `depart_o[k]` is 1 in the same cycle as the arrival strobe of the state that follows k. Every departure strobe comes with exactly one arrival strobe.
- R7: In the first cycle after `rst_n` rises, `arrive_o[0]` is 1 and `depart_o` is all zero.
- R8: Both values of `STROBE_MODE` (0 = compare with the previous state, 1 = strobes registered on the transition) give identical values on every output in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | Advance request, sampled in idle only |
| state_o | output | 2 | Current state code |
| busy_n_o | output | 1 | Level action, high while idle |
| arrive_o | output | 3 | One-cycle arrival strobe, one bit per state |
| depart_o | output | 3 | One-cycle departure strobe, one bit per state |

## Verification
The bench builds two copies side by side, one with `STROBE_MODE`=0 and one with `STROBE_MODE`=1. It compares both against the same reference model on every cycle, which makes the equivalence in R8 visible cycle by cycle. The stimulus holds idle for several cycles and then applies back-to-back requests that arrive while the machine is in the step states. It also applies a reset in mid-sequence, so the arrival strobe that follows reset and the single-pulse behaviour are exercised in both variants.

// File: rtl/efsm_pkg.sv
// Shared types for the three-state action controller.
// Assumes three states; the code width is derived from the count.
package efsm_pkg;
    localparam int NUM_ST = 3;
    localparam int ST_W   = $clog2(NUM_ST);

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 2'd0,
        ST_STEPA = 2'd1,
        ST_STEPB = 2'd2
    } st_e;
endpackage

// File: rtl/efsm_next.sv
// Next-state logic for the three-state controller.
// Idle waits for adv_i, and the two step states each last one cycle.
// Any code outside the three legal values goes back to idle.
module efsm_next
    import efsm_pkg::*;
(
    input  st_e  cur_i,
    input  logic adv_i,
    output st_e  nxt_o
);
    // Purpose: choose the successor of the current state.
    always_comb begin
        case (cur_i)
            ST_IDLE:  nxt_o = adv_i ? ST_STEPA : ST_IDLE;
            ST_STEPA: nxt_o = ST_STEPB;
            ST_STEPB: nxt_o = ST_IDLE;
            default:  nxt_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/efsm_strobe_cmp.sv
// Strobe generator, compare variant. It keeps a registered copy of the
// previous state. A strobe fires when the current and previous codes
// differ. The copy resets to an illegal code, so idle counts as entered
// in the first cycle after reset.
module efsm_strobe_cmp
    import efsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               cur_i,
    output logic [NUM_ST-1:0] arrive_o,
    output logic [NUM_ST-1:0] depart_o
);
    localparam logic [ST_W-1:0] PREV_RST = {ST_W{1'b1}};

    logic [ST_W-1:0] prev_q;

    // Purpose: track the state code of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= PREV_RST;
        else        prev_q <= cur_i;
    end

    for (genvar k = 0; k < NUM_ST; k++) begin : g_cmp
        localparam logic [ST_W-1:0] CODE = ST_W'(k);
        // Purpose: arrival when now in k and was not; departure the reverse.
        always_comb begin
            arrive_o[k] = rst_n && (cur_i == CODE) && (prev_q != CODE);
            depart_o[k] = rst_n && (prev_q == CODE) && (cur_i != CODE);
        end
    end
endmodule

// File: rtl/efsm_strobe_path.sv
// Strobe generator, transition variant. The strobes are registered on
// the edge where the next-state logic picks a different state, so they
// appear in the first cycle the new state is visible. Reset preloads the
// idle arrival strobe so that it matches the compare variant.
module efsm_strobe_path
    import efsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               cur_i,
    input  st_e               nxt_i,
    output logic [NUM_ST-1:0] arrive_o,
    output logic [NUM_ST-1:0] depart_o
);
    logic [NUM_ST-1:0] arrive_q;
    logic [NUM_ST-1:0] depart_q;

    // Purpose: capture one-hot strobes on each change of state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arrive_q <= NUM_ST'(1);
            depart_q <= '0;
        end else begin
            arrive_q <= '0;
            depart_q <= '0;
            if (nxt_i != cur_i) begin
                arrive_q[int'(nxt_i)] <= 1'b1;
                if (int'(cur_i) < NUM_ST) depart_q[int'(cur_i)] <= 1'b1;
            end
        end
    end

    // Purpose: keep the strobes quiet while reset is held.
    always_comb begin
        arrive_o = rst_n ? arrive_q : '0;
        depart_o = rst_n ? depart_q : '0;
    end
endmodule

// File: rtl/entry_exit_fsm.sv
// Top of the three-state controller with arrival and departure strobes.
// It holds the state register and drives the level action. STROBE_MODE
// picks the strobe generator: 0 compares with the previous state, and 1
// registers the strobes on the transition. Reset is synchronous and active low.
module entry_exit_fsm
    import efsm_pkg::*;
#(
    parameter int STROBE_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [ST_W-1:0]   state_o,
    output logic              busy_n_o,
    output logic [NUM_ST-1:0] arrive_o,
    output logic [NUM_ST-1:0] depart_o
);
    st_e state_q;
    st_e state_d;

    efsm_next u_next (
        .cur_i (state_q),
        .adv_i (adv_i),
        .nxt_o (state_d)
    );

    // Purpose: hold the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: drive the state code and the level action while idle.
    always_comb begin
        state_o  = state_q;
        busy_n_o = (state_q == ST_IDLE);
    end

    if (STROBE_MODE == 0) begin : g_cmp
        efsm_strobe_cmp u_strb (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_i    (state_q),
            .arrive_o (arrive_o),
            .depart_o (depart_o)
        );
    end else begin : g_path
        efsm_strobe_path u_strb (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_i    (state_q),
            .nxt_i    (state_d),
            .arrive_o (arrive_o),
            .depart_o (depart_o)
        );
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !adv_i) |=> (state_q == ST_IDLE)); // R2
    AST_IDLE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && adv_i) |=> (state_q == ST_STEPA)); // R2
    AST_STEPA_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEPA) |=> (state_q == ST_STEPB)); // R3
    AST_STEPB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEPB) |=> (state_q == ST_IDLE)); // R3
    AST_ARRIVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arrive_o)); // R5
    AST_NO_ARRIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q == $past(state_q)) |-> (arrive_o == '0)); // R5
    AST_DEPART_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (depart_o != '0) |-> ($countones(arrive_o) == 1)); // R6
    AST_RESET_ARRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (arrive_o[0] && depart_o == '0)); // R7
endmodule

// File: tb/tb_entry_exit_fsm.sv
// Bench: both strobe variants run side by side against one behavioural model.
module tb_entry_exit_fsm;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv = 1'b0;

    logic [1:0] st_a, st_b;
    logic       bz_a, bz_b;
    logic [2:0] ar_a, ar_b, dp_a, dp_b;

    int n_chk = 0;
    int n_bad = 0;

    // model state: m_cur current code, m_prev previous (-1 = none)
    int m_cur = 0;
    int m_prev = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    entry_exit_fsm #(.STROBE_MODE(0)) dut (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .state_o(st_a),
        .busy_n_o(bz_a), .arrive_o(ar_a), .depart_o(dp_a));

    entry_exit_fsm #(.STROBE_MODE(1)) dut_path (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .state_o(st_b),
        .busy_n_o(bz_b), .arrive_o(ar_b), .depart_o(dp_b));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare both instances against the model expectations.
    task automatic compare();
        int ea = 0;
        int ed = 0;
        if (rst_n) begin
            if (m_prev != m_cur) begin
                ea = 1 << m_cur;
                if (m_prev >= 0) ed = 1 << m_prev;
            end
        end
        chk("R2/R3 state mode0", int'(st_a), m_cur);
        chk("R4 busy_n mode0", int'(bz_a), (m_cur == 0) ? 1 : 0);
        chk("R5/R7 arrive mode0", int'(ar_a), ea);
        chk("R6 depart mode0", int'(dp_a), ed);
        chk("R8 state mode1", int'(st_b), m_cur);
        chk("R8 busy_n mode1", int'(bz_b), (m_cur == 0) ? 1 : 0);
        chk("R8 arrive mode1", int'(ar_b), ea);
        chk("R8 depart mode1", int'(dp_b), ed);
    endtask

    // One cycle: apply adv, take the edge, update the model, check at negedge.
    task automatic step(input logic a);
        adv = a;
        @(posedge clk);
        if (!rst_n) begin
            m_cur = 0;
            m_prev = -1;
        end else begin
            m_prev = m_cur;
            case (m_cur)
                0: m_cur = a ? 1 : 0;
                1: m_cur = 2;
                default: m_cur = 0;
            endcase
        end
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < cycles; i++) step(1'b1);
        // R1: strobes low during reset, state idle
        compare();
        rst_n = 1'b1;
        #1;
        // R7: first cycle after release shows idle arrival
        compare();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset(3);
        // R2: hold idle without requests
        for (int i = 0; i < 4; i++) step(1'b0);
        // R3: single request, adv dropped during steps
        step(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0);
        // R3: adv held high through the steps has no effect there
        for (int i = 0; i < 9; i++) step(1'b1);
        // mixed pattern
        for (int i = 0; i < 40; i++) step(((i * 7) % 5) < 2);
        // reset in mid-sequence (R1, R7)
        step(1'b1);
        do_reset(2);
        for (int i = 0; i < 12; i++) step((i % 3) == 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule